// File: doc/BRIEF.md
# I2C Line Control Register

This block is an 8-bit control and monitor register that sits beside an I2C controller and gives software direct access to the two bus wires. Software can pull SCL or SDA low by hand and can read the synchronized level of each wire. It can also ask for one extra SCL clock pulse, for example to free a target that is holding SDA low after an interrupted transfer. The register also holds the controller enable and an internal-reset bit. Together these two bits produce the reset requests for the protocol engine. The start/stop detector, byte engine and bit counter live outside this block.

The manual line bits are guarded by a write key. A write changes the two output-control bits only when that same write carries 0 in the key bit. The key bit itself always reads back as 1, so a read-modify-write of the register never unlocks the manual bits by accident. The extra-clock bit clears itself once its pulse has been produced. The pulse drives SCL low for `HALF_CYCLES` system clocks and then releases it for the same number of clocks.

Both line outputs are open-drain enables, where 1 means pull the wire low. The wire inputs pass through a `SYNC_STAGES`-deep flop chain before they are readable.

Top module: `i2c_line_ctl`

## Requirements
- R1: After reset the register reads 8'h1F: enable, internal reset and extra-clock bits are 0. The key bit, both output-control bits and both monitor bits read 1 while the wires are high. Both output enables and all reset requests are 0.
- R2: Bit 1 reads the SCL wire level and bit 0 reads the SDA wire level, each delayed by exactly two clock edges through the synchronizer. Writes to bits 1:0 have no effect on them.
- R3: Bit 4, the write key, reads as 1 at all times.
- R4: A write updates bit 3 (SCL output control) and bit 2 (SDA output control) from the write data only when write-data bit 4 is 0. When bit 4 is 1, both bits keep their previous value.
- R5: While bit 7 (enable) is 1, an output-control bit at 0 asserts that wire's output enable (wire driven low), and an output-control bit at 1 deasserts it (wire released). Bits 3:2 read back the latched control values.
- R6: While bit 7 is 0, both output enables are 0 whatever the other bits hold.
- R7: Writing 1 to bit 5 starts an extra SCL pulse. For the first HALF_CYCLES clocks after the write edge, the SCL output enable is 1. For the next HALF_CYCLES clocks it follows bit 3 again. Bit 5 reads 1 for those 2*HALF_CYCLES clocks and then reads 0 without any write.
- R8: A write of 1 to bit 5 while a pulse is in progress is ignored, and the running pulse neither restarts nor lengthens.
- R9: While bit 6 (internal reset) is 1, bits 3:2 read 11, the bit-counter clear output is 1, and writes of 1 to bit 5 are ignored. A pulse already in progress is cancelled one clock after bit 6 becomes 1.
- R10: With bit 6 at 1, the full-reset request is asserted when bit 7 is 0 and the internal-only reset request is asserted when bit 7 is 1. The two are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register address decode hit |
| reg_wr | input | 1 | Write strobe, qualified by reg_sel |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, current register view |
| scl_in | input | 1 | SCL wire level |
| sda_in | input | 1 | SDA wire level |
| scl_oe | output | 1 | SCL open-drain enable, 1 pulls the wire low |
| sda_oe | output | 1 | SDA open-drain enable, 1 pulls the wire low |
| full_rst | output | 1 | Full reset request to the protocol engine |
| core_rst | output | 1 | Internal-only reset request to the protocol engine |
| bitcnt_clr | output | 1 | Bit counter clear request |

## Verification
The bench builds the block with HALF_CYCLES = 3 and SYNC_STAGES = 2. With these values a whole extra pulse lasts six clocks, so the bench can check the low half, the released half and the self-clear edge one clock at a time. A second pulse request can also land inside the low half of a running pulse. The two-stage chain makes the wire-monitor delay short enough to see the level before and after each synchronizer edge. The short pulse also leaves room to cancel a pulse with the internal-reset bit while SCL is still held low.

// File: rtl/i2c_line_pkg.sv
package i2c_line_pkg;

    // Register view; field order is the bit order software sees (MSB first).
    typedef struct packed {
        logic en;      // [7] controller enable
        logic irst;    // [6] internal reset
        logic xclk;    // [5] extra SCL pulse request / busy
        logic key;     // [4] write key for the manual line bits
        logic scl_o;   // [3] SCL output control (0 = drive low)
        logic sda_o;   // [2] SDA output control (0 = drive low)
        logic scl_m;   // [1] SCL wire monitor
        logic sda_m;   // [0] SDA wire monitor
    } ctl_view_t;

    typedef enum logic [1:0] {
        XC_IDLE = 2'd0,
        XC_LOW  = 2'd1,
        XC_HIGH = 2'd2
    } xclk_phase_t;

    typedef struct packed {
        logic full;
        logic internal;
        logic bitcnt;
    } rst_req_t;

    function automatic rst_req_t decode_rst(input logic en, input logic irst);
        rst_req_t r;
        r.full     = irst & ~en;
        r.internal = irst & en;
        r.bitcnt   = irst;
        return r;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // STAGES must be at least 2. Reset value 1 matches an idle pulled-up bus.
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_line_xclk.sv
module i2c_line_xclk
    import i2c_line_pkg::*;
#(
    parameter int HALF_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic start,
    output logic busy,
    output logic drive_low
);
    localparam int              CW     = $clog2(HALF_CYCLES + 1);
    localparam logic [CW-1:0]   RELOAD = CW'(HALF_CYCLES - 1);

    xclk_phase_t   phase;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= XC_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                XC_IDLE: begin
                    if (start) begin
                        phase <= XC_LOW;
                        cnt   <= RELOAD;
                    end
                end
                XC_LOW: begin
                    if (cnt == '0) begin
                        phase <= XC_HIGH;
                        cnt   <= RELOAD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                XC_HIGH: begin
                    if (cnt == '0) begin
                        phase <= XC_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    phase <= XC_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign busy      = (phase != XC_IDLE);
    assign drive_low = (phase == XC_LOW);
endmodule

// File: rtl/i2c_line_ctl.sv
module i2c_line_ctl
    import i2c_line_pkg::*;
#(
    parameter int HALF_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_sel,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       full_rst,
    output logic       core_rst,
    output logic       bitcnt_clr
);
    ctl_view_t wv;
    ctl_view_t rv;
    rst_req_t  rq;
    logic      wr_hit;
    logic      en_q, irst_q, scl_q, sda_q;
    logic      irst_nxt;
    logic      xc_start, xc_busy, xc_low;
    logic [1:0] mon;
    logic       unused_wr_mon;

    assign wr_hit        = reg_sel & reg_wr;
    assign wv            = ctl_view_t'(reg_wdata);
    assign unused_wr_mon = wv.scl_m ^ wv.sda_m;

    // Internal reset takes effect on the latches in the same edge it is written.
    assign irst_nxt = wr_hit ? wv.irst : irst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            irst_q <= 1'b0;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            if (wr_hit) begin
                en_q   <= wv.en;
                irst_q <= wv.irst;
            end
            if (irst_nxt) begin
                scl_q <= 1'b1;
                sda_q <= 1'b1;
            end else if (wr_hit && !wv.key) begin
                scl_q <= wv.scl_o;
                sda_q <= wv.sda_o;
            end
        end
    end

    assign xc_start = wr_hit & wv.xclk & ~irst_nxt;

    i2c_line_xclk #(
        .HALF_CYCLES(HALF_CYCLES)
    ) u_xclk (
        .clk      (clk),
        .rst      (rst),
        .clr      (irst_q),
        .start    (xc_start),
        .busy     (xc_busy),
        .drive_low(xc_low)
    );

    i2c_line_sync #(
        .STAGES(SYNC_STAGES),
        .WIDTH (2)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({scl_in, sda_in}),
        .q  (mon)
    );

    always_comb begin
        rv.en    = en_q;
        rv.irst  = irst_q;
        rv.xclk  = xc_busy;
        rv.key   = 1'b1;
        rv.scl_o = scl_q;
        rv.sda_o = sda_q;
        rv.scl_m = mon[1];
        rv.sda_m = mon[0];
    end

    assign reg_rdata = rv;

    assign scl_oe = en_q & (~scl_q | xc_low);
    assign sda_oe = en_q & ~sda_q;

    assign rq         = decode_rst(en_q, irst_q);
    assign full_rst   = rq.full;
    assign core_rst   = rq.internal;
    assign bitcnt_clr = rq.bitcnt;
endmodule

// File: rtl/i2c_line_ctl_chk.sv
module i2c_line_ctl_chk #(
    parameter int HALF_CYCLES = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       reg_sel,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       full_rst,
    input logic       core_rst,
    input logic       bitcnt_clr
);
    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !reg_rdata[5]) run_len <= '0;
        else                      run_len <= run_len + 1'b1;
    end

    a_r3_key_reads_one: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[4]);

    a_r4_locked_write_keeps: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_wr && reg_wdata[4] && !reg_wdata[6]) |=> $stable(reg_rdata[3:2]));

    a_r5_sda_follows_latch: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[7] |-> (sda_oe == !reg_rdata[2]));

    a_r6_disabled_released: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata[7] |-> (!scl_oe && !sda_oe));

    a_r7_pulse_starts_low: assert property (@(posedge clk) disable iff (rst)
        ($rose(reg_rdata[5]) && reg_rdata[7]) |-> scl_oe);

    a_r8_pulse_length: assert property (@(posedge clk) disable iff (rst)
        ($fell(reg_rdata[5]) && !reg_rdata[6]) |-> (run_len == 16'(2 * HALF_CYCLES)));

    a_r9_irst_releases: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[6] |-> (reg_rdata[3:2] == 2'b11 && bitcnt_clr));

    a_r10_reset_split: assert property (@(posedge clk) disable iff (rst)
        $onehot0({full_rst, core_rst}) && ((full_rst || core_rst) == bitcnt_clr));
endmodule

bind i2c_line_ctl i2c_line_ctl_chk #(
    .HALF_CYCLES(HALF_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .full_rst  (full_rst),
    .core_rst  (core_rst),
    .bitcnt_clr(bitcnt_clr)
);

// File: tb/i2c_line_ctl_tb.sv
`timescale 1ns/1ps
module i2c_line_ctl_tb;
    localparam int H = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       scl_oe, sda_oe, full_rst, core_rst, bitcnt_clr;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct {
        logic [7:0] rd;
        logic       soe;
        logic       doe;
        logic       fr;
        logic       cr;
        logic       bc;
        string      req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    i2c_line_ctl #(.HALF_CYCLES(H), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .full_rst(full_rst), .core_rst(core_rst), .bitcnt_clr(bitcnt_clr)
    );

    // Monitor: pops expected items and compares them just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                logic [12:0] act, exp;
                e   = sb.pop_front();
                act = {reg_rdata, scl_oe, sda_oe, full_rst, core_rst, bitcnt_clr};
                exp = {e.rd, e.soe, e.doe, e.fr, e.cr, e.bc};
                n_chk++;
                if (act !== exp) begin
                    n_fail++;
                    $display("FAIL %s: actual rdata=%h oe=%b%b rst=%b%b%b expected rdata=%h oe=%b%b rst=%b%b%b",
                             e.req, act[12:5], act[4], act[3], act[2], act[1], act[0],
                             exp[12:5], exp[4], exp[3], exp[2], exp[1], exp[0]);
                end
            end
        end
    end

    task automatic expect_state(input logic [7:0] rd, input logic soe, input logic doe,
                                input logic fr, input logic cr, input logic bc,
                                input string req);
        exp_t e;
        e.rd = rd; e.soe = soe; e.doe = doe; e.fr = fr; e.cr = cr; e.bc = bc; e.req = req;
        sb.push_back(e);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_sel   = 1'b1;
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_sel   = 1'b0;
        reg_wr    = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual not finished expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset view; every readback below also carries bit 4 = 1 (R3)
        expect_state(8'h1F, 0, 0, 0, 0, 0, "R1 reset");

        wr(8'h00);
        expect_state(8'h13, 0, 0, 0, 0, 0, "R6 disabled with latches low");
        wr(8'h80);
        expect_state(8'h93, 1, 1, 0, 0, 0, "R5 both lines driven low");
        wr(8'h9C);
        expect_state(8'h93, 1, 1, 0, 0, 0, "R4 R3 locked write keeps latches");
        wr(8'h88);
        expect_state(8'h9B, 0, 1, 0, 0, 0, "R5 SCL released SDA low");

        // R2 monitor delay
        scl_in = 1'b0;
        sda_in = 1'b0;
        tick();
        expect_state(8'h9B, 0, 1, 0, 0, 0, "R2 after one edge");
        tick();
        expect_state(8'h98, 0, 1, 0, 0, 0, "R2 after two edges");
        wr(8'h8B);
        expect_state(8'h98, 0, 1, 0, 0, 0, "R2 monitor bits not writable");
        scl_in = 1'b1;
        sda_in = 1'b1;
        tick();
        tick();
        expect_state(8'h9B, 0, 1, 0, 0, 0, "R2 lines back high");

        // R7 single extra pulse
        wr(8'h8C);
        expect_state(8'h9F, 0, 0, 0, 0, 0, "R5 both released");
        wr(8'hAC);
        for (int k = 0; k <= 2 * H; k++) begin
            expect_state((k < 2 * H) ? 8'hBF : 8'h9F, (k < H), 0, 0, 0, 0, "R7 pulse shape");
            if (k < 2 * H) tick();
        end

        // R8 second request during a pulse
        wr(8'hAC);
        expect_state(8'hBF, 1, 0, 0, 0, 0, "R8 pulse start");
        wr(8'hAC);
        for (int k = 2; k <= 2 * H; k++) begin
            expect_state((k < 2 * H) ? 8'hBF : 8'h9F, (k < H), 0, 0, 0, 0, "R8 request ignored");
            if (k < 2 * H) tick();
        end

        // R9 internal reset cancels a pulse and releases latches
        wr(8'hA0);
        expect_state(8'hB3, 1, 1, 0, 0, 0, "R9 setup pulse with lines low");
        wr(8'hC0);
        expect_state(8'hFF, 1, 0, 0, 1, 1, "R9 latches released");
        tick();
        expect_state(8'hDF, 0, 0, 0, 1, 1, "R9 pulse cancelled");
        wr(8'hE0);
        expect_state(8'hDF, 0, 0, 0, 1, 1, "R9 pulse request ignored");

        // R10 reset split
        wr(8'h40);
        expect_state(8'h5F, 0, 0, 1, 0, 1, "R10 full reset");
        wr(8'h8C);
        expect_state(8'h9F, 0, 0, 0, 0, 0, "R10 reset released");

        tick();
        tick();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule